// File: doc/BRIEF.md
# Two-Rate Ring Tone Generator

This block drives a square ring tone toward a subscriber line interface circuit. It has no clock divider of its own. Its only time base is the 8 kHz frame-sync strobe, a single-cycle pulse in the system clock domain. The output toggles after a fixed number of strobes. With the default parameters, one select value gives 250 strobes per half period (16 Hz) and the other gives 200 strobes per half period (20 Hz).

Three control bits come straight from a register file:
- a rate select;
- an enable;
- a power-down that belongs to this block alone.

When power-down is released, a wake-up counter waits a set number of strobes before it raises the ready flag. The default is one strobe, which is 125 µs. The tone can only start once ready is high.

All changes to rate and enable wait for the next half-period boundary. This keeps the output free of short pulses. While the tone is disabled, the output rests low.

Top module: `ring_tone_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `tone_out` and `tone_ready` are 0.
- R2: A cycle with `tone_pd` = 1 clears `tone_out` and `tone_ready` at the next clock edge, whether or not a strobe is present. While `tone_ready` is 0, `tone_out` is 0.
- R3: After `tone_pd` returns to 0, `tone_ready` rises at the edge of the WAKE_STROBES-th strobe (default 1). Strobes taken while `tone_pd` = 1 do not count.
- R4: Apart from the clearing in R1 and R2, `tone_out` changes only at an edge where `fs_strobe` = 1.
- R5: An idle generator starts with `tone_out` = 1 at the first strobe on which `tone_ready` was already 1 and `tone_en` = 1. A rise of `tone_out` needs `tone_en` = 1 in the previous cycle.
- R6: `tone_sel` = 0 selects the slow rate and `tone_sel` = 1 selects the fast rate. Each half period lasts HALF_SLOW strobes (default 250) or HALF_FAST strobes (default 200).
- R7: A change of `tone_sel` during a half period has no effect until the next half-period boundary. At that boundary the new rate governs the next half period.
- R8: `tone_en` = 0 has an effect only at a half-period boundary. At that boundary the output goes to 0 and stays there until a later start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fs_strobe | input | 1 | One-cycle pulse per 8 kHz frame |
| tone_sel | input | 1 | Rate select: 0 slow, 1 fast |
| tone_en | input | 1 | Tone on/off |
| tone_pd | input | 1 | Generator power-down |
| tone_out | output | 1 | Square ring tone |
| tone_ready | output | 1 | Wake-up complete |

## Verification
The bench builds the block with HALF_SLOW = 4, HALF_FAST = 3 and WAKE_STROBES = 2. With these values every boundary is a few strobes apart, so a single table can cover the following:
- both rates;
- a rate change in the middle of a half period;
- a disable during a high half and during a low half;
- a restart after power-down.

A wake-up length of two separates the rule "ready after N strobes" from the rule "ready on the next strobe". Because the two half periods have different lengths, a rate change that is applied too early lands on a wrong boundary, and the bench sees the output change.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    typedef enum logic {
        RATE_SLOW = 1'b0,
        RATE_FAST = 1'b1
    } rate_e;

    typedef struct packed {
        logic  running;
        logic  level;
        rate_e rate;
    } gen_state_t;

    function automatic int unsigned half_len(rate_e r, int unsigned slow, int unsigned fast);
        return (r == RATE_FAST) ? fast : slow;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rtg_wake.sv
module rtg_wake #(
    parameter int unsigned WAKE_STROBES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic pd,
    input  logic strobe,
    output logic ready
);
    localparam int unsigned WW = $clog2(WAKE_STROBES + 1);

    logic [WW-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst || pd) begin
            seen  <= '0;
            ready <= 1'b0;
        end else if (strobe && !ready) begin
            if (seen == WW'(WAKE_STROBES - 1)) begin
                ready <= 1'b1;
                seen  <= '0;
            end else begin
                seen <= seen + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtg_divider.sv
module rtg_divider #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          start,
    input  logic          tick,
    input  logic [CW-1:0] half,
    output logic          boundary
);
    logic [CW-1:0] cnt;

    assign boundary = (cnt == half - 1'b1);

    always_ff @(posedge clk) begin
        if (clr || start) begin
            cnt <= '0;
        end else if (tick) begin
            if (boundary) cnt <= '0;
            else          cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ring_tone_gen.sv
module ring_tone_gen
    import rtg_pkg::*;
#(
    parameter int unsigned HALF_SLOW    = 250,
    parameter int unsigned HALF_FAST    = 200,
    parameter int unsigned WAKE_STROBES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic fs_strobe,
    input  logic tone_sel,
    input  logic tone_en,
    input  logic tone_pd,
    output logic tone_out,
    output logic tone_ready
);
    localparam int unsigned CW = $clog2(max2(HALF_SLOW, HALF_FAST) + 1);

    gen_state_t    st;
    logic          ready;
    logic          clr;
    logic          live;
    logic          start;
    logic          tick;
    logic          boundary;
    logic [CW-1:0] half;

    rtg_wake #(.WAKE_STROBES(WAKE_STROBES)) u_wake (
        .clk    (clk),
        .rst    (rst),
        .pd     (tone_pd),
        .strobe (fs_strobe),
        .ready  (ready)
    );

    assign clr   = rst || tone_pd || !ready;
    assign live  = fs_strobe && !clr;
    assign start = live && !st.running && tone_en;
    assign tick  = live && st.running;
    assign half  = CW'(half_len(st.rate, HALF_SLOW, HALF_FAST));

    rtg_divider #(.CW(CW)) u_div (
        .clk      (clk),
        .clr      (clr),
        .start    (start),
        .tick     (tick),
        .half     (half),
        .boundary (boundary)
    );

    always_ff @(posedge clk) begin
        if (clr) begin
            st <= '{running: 1'b0, level: 1'b0, rate: RATE_SLOW};
        end else if (start) begin
            st <= '{running: 1'b1, level: 1'b1, rate: rate_e'(tone_sel)};
        end else if (tick && boundary) begin
            if (tone_en) begin
                st.level <= ~st.level;
                st.rate  <= rate_e'(tone_sel);
            end else begin
                st.running <= 1'b0;
                st.level   <= 1'b0;
            end
        end
    end

    assign tone_out   = st.level;
    assign tone_ready = ready;
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker (
    input logic clk,
    input logic rst,
    input logic fs_strobe,
    input logic tone_en,
    input logic tone_pd,
    input logic tone_out,
    input logic tone_ready
);
    // R2
    pd_clears_chk: assert property (@(posedge clk) disable iff (rst)
        tone_pd |=> (!tone_ready && !tone_out));

    // R2
    quiet_unready_chk: assert property (@(posedge clk) disable iff (rst)
        !tone_ready |-> !tone_out);

    // R3
    ready_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tone_ready) |-> ($past(fs_strobe) && !$past(tone_pd)));

    // R4
    edge_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (!fs_strobe && !tone_pd) |=> $stable(tone_out));

    // R5
    start_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tone_out) |-> ($past(tone_en) && $past(tone_ready)));
endmodule

bind ring_tone_gen rtg_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .fs_strobe  (fs_strobe),
    .tone_en    (tone_en),
    .tone_pd    (tone_pd),
    .tone_out   (tone_out),
    .tone_ready (tone_ready)
);

// File: tb/tb_ring_tone_gen.sv
module tb_ring_tone_gen;
    logic clk = 1'b0;
    logic rst, fs_strobe, tone_sel, tone_en, tone_pd;
    logic tone_out, tone_ready;
    int   errors = 0;
    int   checks = 0;
    bit   done = 0;

    always #2.5 clk = ~clk;

    ring_tone_gen #(.HALF_SLOW(4), .HALF_FAST(3), .WAKE_STROBES(2)) dut (
        .clk(clk), .rst(rst), .fs_strobe(fs_strobe), .tone_sel(tone_sel),
        .tone_en(tone_en), .tone_pd(tone_pd),
        .tone_out(tone_out), .tone_ready(tone_ready)
    );

    // each row: {pd, en, sel, expected out, expected ready} after one strobe
    localparam int N = 36;
    localparam logic [4:0] VEC [N] = '{
        5'b10000, 5'b01000, 5'b01001, 5'b01011, 5'b01011, 5'b01011,
        5'b01011, 5'b01001, 5'b01001, 5'b01101, 5'b01101, 5'b01111,
        5'b01111, 5'b01111, 5'b01101, 5'b01101, 5'b01101, 5'b01111,
        5'b00111, 5'b00111, 5'b00101, 5'b00101, 5'b01011, 5'b01011,
        5'b01011, 5'b01011, 5'b01001, 5'b01001, 5'b01001, 5'b00001,
        5'b00001, 5'b00001, 5'b11000, 5'b01000, 5'b01001, 5'b01011
    };

    task automatic check(string req, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: out/ready actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic string req_of(int i);
        if (i <= 2 || i >= 32) return "R3";
        if (i <= 7)            return "R6";
        if (i <= 17)           return "R7";
        return "R8";
    endfunction

    initial begin
        rst = 1; fs_strobe = 0; tone_sel = 0; tone_en = 0; tone_pd = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 during reset", {tone_out, tone_ready}, 2'b00);
        rst = 0;
        @(negedge clk);
        check("R1 after reset", {tone_out, tone_ready}, 2'b00);

        for (int i = 0; i < N; i++) begin
            tone_pd = VEC[i][4]; tone_en = VEC[i][3]; tone_sel = VEC[i][2];
            fs_strobe = 1;
            @(negedge clk);
            fs_strobe = 0;
            check(req_of(i), {tone_out, tone_ready}, VEC[i][1:0]);
            @(negedge clk);
            check("R4 idle hold", {tone_out, tone_ready}, VEC[i][1:0]);
        end

        // R2: power-down without strobe while tone is high
        tone_pd = 1;
        @(negedge clk);
        check("R2 pd no strobe", {tone_out, tone_ready}, 2'b00);
        // R3: strobe during pd does not count toward wake-up
        fs_strobe = 1;
        @(negedge clk);
        fs_strobe = 0; tone_pd = 0;
        @(negedge clk);
        fs_strobe = 1;
        @(negedge clk);
        fs_strobe = 0;
        check("R3 pd strobe ignored", {tone_out, tone_ready}, 2'b00);
        // R5: en low keeps generator idle once ready
        tone_en = 0;
        fs_strobe = 1;
        @(negedge clk);
        check("R3 ready second strobe", {tone_out, tone_ready}, 2'b01);
        @(negedge clk);
        fs_strobe = 0;
        check("R5 idle without en", {tone_out, tone_ready}, 2'b01);
        tone_en = 1;
        fs_strobe = 1;
        @(negedge clk);
        fs_strobe = 0;
        check("R5 start", {tone_out, tone_ready}, 2'b11);
        // R1: reset mid-tone
        rst = 1;
        @(negedge clk);
        check("R1 mid reset", {tone_out, tone_ready}, 2'b00);
        rst = 0;
        done = 1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule